// File: doc/BRIEF.md
# Shared-ALU Multi-Cycle Processor Core

This block is a compact processor for a 32-bit RISC integer subset. It runs word loads and stores, register-to-register arithmetic, compare-and-branch on equality and absolute jumps. Instruction fetches and data accesses go through one memory port. The same ALU produces the incremented program counter, the branch target, effective addresses and arithmetic results. Each instruction is spread over several clock cycles. Holding registers carry the partial results from one cycle to the next, so no cycle needs more than one memory access, one register-file access or one ALU operation.

A finite-state sequencer drives every multiplexer select and write enable. The memory on the other side is a plain word memory. It takes writes on the clock edge and returns read data for the address presented in the same cycle. Each instruction uses opcode in bits 31:26, first source register in 25:21, second source or load target in 20:16, destination in 15:11, function code in 5:0, and a 16-bit immediate in 15:0.

Top module: `mc_core`

## Requirements
- R1: While reset is low, the program counter holds RST_PC (default 0) and the sequencer is in the fetch step, so mem_rd is 1, mem_wr is 0 and mem_addr equals RST_PC. All general registers reset to zero.
- R2: Every instruction begins with a single fetch cycle. In that cycle mem_rd is 1 and mem_addr is the program counter. At the end of the cycle the instruction is captured and the program counter advances by 4, with the sum produced by the shared ALU.
- R3: Cycle counts per instruction, fetch included: load (opcode 0x23) takes 5, store (0x2B) takes 4, register arithmetic (0x00) takes 4, branch-if-equal (0x04) takes 3 and jump (0x02) takes 3. Any other opcode takes 2 cycles and has no effect beyond the PC advance.
- R4: A load reads memory in its 4th cycle, with mem_rd=1 and mem_addr = register[25:21] + sign-extended immediate. The word read is written to register[20:16] in the 5th cycle.
- R5: A store drives mem_wr=1 in its 4th cycle, for that one cycle only. mem_addr is register[25:21] + sign-extended immediate and mem_wdata is register[20:16].
- R6: Register arithmetic writes register[15:11] with the result selected by the function code: 0x20 add, 0x22 subtract, 0x24 bitwise and, 0x25 bitwise or, 0x2A signed set-if-less-than (1 or 0). Any other function code adds.
- R7: A branch-if-equal compares register[25:21] with register[20:16]. When they are equal, the next fetch is at PC+4 + (sign-extended immediate × 4). Otherwise it is at PC+4.
- R8: A jump makes the next fetch address {upper 4 bits of PC+4, instruction bits 25:0, 2'b00}.
- R9: Register 0 always reads as zero, and writes to it are ignored.
- R10: mem_rd and mem_wr are never high together. Neither strobe is high outside the fetch cycle and the memory cycle of a load or store.
- R11: The program counter changes only at the end of a fetch, branch or jump cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 32 | Byte address for the shared memory port |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Word returned for mem_addr in the same cycle |
| mem_rd | output | 1 | Read strobe (fetch or load) |
| mem_wr | output | 1 | Write strobe (store) |

## Verification
The program mixes loads from positive offsets and stores through a nonzero base register, so address arithmetic is separated from plain immediate passing. All five arithmetic functions run on a positive and a negative operand; signed set-if-less-than is tried in both operand orders, which separates a signed compare from an unsigned one. Branches are tried not-taken, taken forward and as a counted backward loop closed by a jump, and a skipped store after each taken branch or jump shows whether the redirect happened. An undefined opcode and a write to register 0 check that neither leaves any trace in the bus activity or in memory.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;

   typedef enum logic [3:0] {
      S_FETCH, S_DECODE, S_MEMADR, S_MEMRD, S_MEMWB,
      S_MEMWR, S_EXEC, S_RTWB, S_BRANCH, S_JUMP
   } state_t;

   localparam logic [5:0] OP_ARITH = 6'h00;
   localparam logic [5:0] OP_JUMP  = 6'h02;
   localparam logic [5:0] OP_BEQ   = 6'h04;
   localparam logic [5:0] OP_LOAD  = 6'h23;
   localparam logic [5:0] OP_STORE = 6'h2B;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_FUNCT} alu_mode_t;
   typedef enum logic [1:0] {OPB_REG, OPB_FOUR, OPB_IMM, OPB_OFS} opb_t;
   typedef enum logic [1:0] {PC_ALU, PC_TGT, PC_JMP} pcsel_t;

   typedef struct packed {
      logic      pc_ld;
      logic      pc_ld_eq;
      logic      addr_from_alu;
      logic      mem_rd;
      logic      mem_wr;
      logic      ir_ld;
      logic      wb_from_mem;
      logic      rf_we;
      logic      dst_rd;
      logic      opa_reg;
      opb_t      opb_sel;
      alu_mode_t alu_mode;
      pcsel_t    pc_sel;
   } ctrl_t;

endpackage

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
module mc_alu #(
   parameter int W = 32
) (
   input  logic [W-1:0]       a,
   input  logic [W-1:0]       b,
   input  mc_pkg::alu_mode_t  mode,
   input  logic [5:0]         funct,
   output logic [W-1:0]       y,
   output logic               zero
);
   import mc_pkg::*;

   always_comb begin
      y = a + b;
      case (mode)
         ALU_SUB: y = a - b;
         ALU_FUNCT: begin
            case (funct)
               FN_SUB:  y = a - b;
               FN_AND:  y = a & b;
               FN_OR:   y = a | b;
               FN_SLT:  y = ($signed(a) < $signed(b)) ? W'(1) : '0;
               default: y = a + b;
            endcase
         end
         default: y = a + b;
      endcase
   end

   assign zero = (y == '0);
endmodule

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
module mc_regfile #(
   parameter int W     = 32,
   parameter int NREG  = 32,
   parameter int NRD   = 2,
   localparam int AW   = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ra [NRD],
   output logic [W-1:0]  rd [NRD],
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd
);
   logic [W-1:0] q [NREG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) q[i] <= '0;
      end else if (we && wa != '0) begin
         q[wa] <= wd;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rport
      assign rd[p] = (ra[p] == '0) ? '0 : q[ra[p]];
   end
endmodule

// File: rtl/mc_ctrl.sv
`timescale 1ns/1ps
module mc_ctrl (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [5:0]     opcode,
   output mc_pkg::ctrl_t  ctl,
   output mc_pkg::state_t st
);
   import mc_pkg::*;

   state_t nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) st <= S_FETCH;
      else        st <= nxt;
   end

   always_comb begin
      ctl = '0;
      nxt = S_FETCH;
      case (st)
         S_FETCH: begin
            ctl.mem_rd   = 1'b1;
            ctl.ir_ld    = 1'b1;
            ctl.opb_sel  = OPB_FOUR;
            ctl.pc_ld    = 1'b1;
            ctl.pc_sel   = PC_ALU;
            nxt          = S_DECODE;
         end
         S_DECODE: begin
            ctl.opb_sel  = OPB_OFS;
            case (opcode)
               OP_LOAD, OP_STORE: nxt = S_MEMADR;
               OP_ARITH:          nxt = S_EXEC;
               OP_BEQ:            nxt = S_BRANCH;
               OP_JUMP:           nxt = S_JUMP;
               default:           nxt = S_FETCH;
            endcase
         end
         S_MEMADR: begin
            ctl.opa_reg  = 1'b1;
            ctl.opb_sel  = OPB_IMM;
            nxt          = (opcode == OP_LOAD) ? S_MEMRD : S_MEMWR;
         end
         S_MEMRD: begin
            ctl.mem_rd        = 1'b1;
            ctl.addr_from_alu = 1'b1;
            nxt               = S_MEMWB;
         end
         S_MEMWB: begin
            ctl.rf_we       = 1'b1;
            ctl.wb_from_mem = 1'b1;
         end
         S_MEMWR: begin
            ctl.mem_wr        = 1'b1;
            ctl.addr_from_alu = 1'b1;
         end
         S_EXEC: begin
            ctl.opa_reg  = 1'b1;
            ctl.opb_sel  = OPB_REG;
            ctl.alu_mode = ALU_FUNCT;
            nxt          = S_RTWB;
         end
         S_RTWB: begin
            ctl.rf_we  = 1'b1;
            ctl.dst_rd = 1'b1;
         end
         S_BRANCH: begin
            ctl.opa_reg  = 1'b1;
            ctl.opb_sel  = OPB_REG;
            ctl.alu_mode = ALU_SUB;
            ctl.pc_ld_eq = 1'b1;
            ctl.pc_sel   = PC_TGT;
         end
         S_JUMP: begin
            ctl.pc_ld  = 1'b1;
            ctl.pc_sel = PC_JMP;
         end
         default: nxt = S_FETCH;
      endcase
   end
endmodule

// File: rtl/mc_core.sv
`timescale 1ns/1ps
module mc_core #(
   parameter int          W      = 32,
   parameter int          NREG   = 32,
   parameter logic [31:0] RST_PC = 32'h0
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [31:0]  mem_addr,
   output logic [31:0]  mem_wdata,
   input  logic [31:0]  mem_rdata,
   output logic         mem_rd,
   output logic         mem_wr
);
   import mc_pkg::*;

   localparam int AW = $clog2(NREG);

   if (W != 32 || NREG != 32) begin : g_bad_size
      $error("mc_core: instruction fields fix W and NREG at 32");
   end
   if (RST_PC[1:0] != 2'b00) begin : g_bad_rst
      $error("mc_core: RST_PC must be word aligned");
   end

   ctrl_t        ctl;
   state_t       st;
   logic [W-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_q;
   logic [W-1:0] opa, opb, alu_y, pc_next, imm_sx;
   logic         alu_zero;
   logic [AW-1:0] ra [2];
   logic [W-1:0]  rdat [2];
   logic [AW-1:0] wa;
   logic [W-1:0]  wd;

   mc_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (ir_q[31:26]),
      .ctl    (ctl),
      .st     (st)
   );

   assign ra[0] = ir_q[25:21];
   assign ra[1] = ir_q[20:16];
   assign wa    = ctl.dst_rd ? ir_q[15:11] : ir_q[20:16];
   assign wd    = ctl.wb_from_mem ? mdr_q : alu_q;

   mc_regfile #(.W(W), .NREG(NREG), .NRD(2)) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .ra    (ra),
      .rd    (rdat),
      .we    (ctl.rf_we),
      .wa    (wa),
      .wd    (wd)
   );

   assign imm_sx = {{(W-16){ir_q[15]}}, ir_q[15:0]};
   assign opa    = ctl.opa_reg ? a_q : pc_q;

   always_comb begin
      case (ctl.opb_sel)
         OPB_REG:  opb = b_q;
         OPB_FOUR: opb = W'(4);
         OPB_IMM:  opb = imm_sx;
         default:  opb = imm_sx << 2;
      endcase
   end

   mc_alu #(.W(W)) u_alu (
      .a     (opa),
      .b     (opb),
      .mode  (ctl.alu_mode),
      .funct (ir_q[5:0]),
      .y     (alu_y),
      .zero  (alu_zero)
   );

   always_comb begin
      case (ctl.pc_sel)
         PC_TGT:  pc_next = alu_q;
         PC_JMP:  pc_next = {pc_q[W-1:W-4], ir_q[25:0], 2'b00};
         default: pc_next = alu_y;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q  <= RST_PC;
         ir_q  <= '0;
         mdr_q <= '0;
         a_q   <= '0;
         b_q   <= '0;
         alu_q <= '0;
      end else begin
         if (ctl.pc_ld || (ctl.pc_ld_eq && alu_zero)) pc_q <= pc_next;
         if (ctl.ir_ld) ir_q <= mem_rdata;
         if (ctl.mem_rd && ctl.addr_from_alu) mdr_q <= mem_rdata;
         a_q   <= rdat[0];
         b_q   <= rdat[1];
         alu_q <= alu_y;
      end
   end

   assign mem_addr  = ctl.addr_from_alu ? alu_q : pc_q;
   assign mem_wdata = b_q;
   assign mem_rd    = ctl.mem_rd;
   assign mem_wr    = ctl.mem_wr;
endmodule

// File: rtl/mc_core_chk.sv
`timescale 1ns/1ps
module mc_core_chk (
   input logic           clk,
   input logic           rst_n,
   input logic           mem_rd,
   input logic           mem_wr,
   input logic [31:0]    mem_addr,
   input logic [31:0]    pc,
   input mc_pkg::state_t st
);
   import mc_pkg::*;

   // R10
   rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R2
   fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_FETCH) |-> (mem_rd && mem_addr == pc));

   // R2
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_FETCH) |=> (pc == $past(pc) + 32'd4));

   // R11
   pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st inside {S_DECODE, S_MEMADR, S_MEMRD, S_MEMWB, S_MEMWR, S_EXEC, S_RTWB})
      |=> $stable(pc));

   // R4
   load_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_MEMRD) |=> (st == S_MEMWB));

   // R5
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr);
endmodule

bind mc_core mc_core_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mem_rd   (mem_rd),
   .mem_wr   (mem_wr),
   .mem_addr (mem_addr),
   .pc       (pc_q),
   .st       (st)
);

// File: tb/mc_core_test.sv
`timescale 1ns/1ps
module mc_core_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_rd, mem_wr;

   always #10 clk = ~clk;

   mc_core uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, int fn);
      return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
   endfunction
   function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
      return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
   endfunction
   function automatic logic [31:0] enc_j(int tgt);
      return {6'h02, tgt[25:0]};
   endfunction

   function automatic logic [31:0] init_word(int i);
      case (i)
         0:  return enc_i(35, 0, 1, 'h200);
         1:  return enc_i(35, 0, 2, 'h204);
         2:  return enc_i(35, 0, 13, 'h208);
         3:  return enc_r(1, 2, 3, 'h20);
         4:  return enc_r(1, 2, 4, 'h22);
         5:  return enc_r(1, 2, 5, 'h24);
         6:  return enc_r(1, 2, 6, 'h25);
         7:  return enc_r(2, 1, 7, 'h2A);
         8:  return enc_r(1, 2, 8, 'h2A);
         9:  return enc_r(1, 1, 0, 'h20);
         10: return enc_i(43, 0, 3, 'h280);
         11: return enc_i(43, 0, 4, 'h284);
         12: return enc_i(43, 0, 5, 'h288);
         13: return enc_i(43, 0, 6, 'h28C);
         14: return enc_i(43, 0, 7, 'h290);
         15: return enc_i(43, 0, 8, 'h294);
         16: return enc_i(43, 0, 0, 'h298);
         17: return 32'hFC00_0000;
         18: return enc_i(4, 1, 2, 5);
         19: return enc_i(4, 1, 1, 1);
         20: return enc_i(43, 0, 1, 'h29C);
         21: return enc_r(9, 1, 9, 'h20);
         22: return enc_i(4, 9, 13, 1);
         23: return enc_j(21);
         24: return enc_i(43, 0, 9, 'h2A0);
         25: return enc_j(27);
         26: return enc_i(43, 0, 1, 'h2A4);
         27: return enc_i(43, 3, 2, 'h2A4);
         28: return enc_j(28);
         128: return 32'd7;
         129: return 32'hFFFF_FFFD;
         130: return 32'd21;
         default: return (i >= 160 && i <= 170) ? 32'hDEAD_BEEF : 32'h0;
      endcase
   endfunction

   // memory seen by the design
   logic [31:0] dmem [256];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) dmem[i] <= init_word(i);
      end else if (mem_wr) begin
         dmem[mem_addr[9:2]] <= mem_wdata;
      end
   end
   assign mem_rdata = dmem[mem_addr[9:2]];

   // behavioural reference model
   logic [31:0] rmem [256];
   logic [31:0] rf [32];
   logic [31:0] mpc, cur_pc, ea, sdata;
   bit          is_lw, is_sw;
   int          phase, ncyc, halts;
   string       ftag, prev_tag;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic decode_next();
      logic [31:0] ins, sx, a, b, r;
      cur_pc = mpc;
      ins    = rmem[mpc[9:2]];
      mpc    = mpc + 32'd4;
      is_lw  = 1'b0;
      is_sw  = 1'b0;
      ftag   = prev_tag;
      sx     = {{16{ins[15]}}, ins[15:0]};
      a      = rf[ins[25:21]];
      b      = rf[ins[20:16]];
      case (ins[31:26])
         6'h00: begin
            case (ins[5:0])
               6'h22:   r = a - b;
               6'h24:   r = a & b;
               6'h25:   r = a | b;
               6'h2A:   r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
               default: r = a + b;
            endcase
            if (ins[15:11] != 5'd0) rf[ins[15:11]] = r;
            ncyc = 4; prev_tag = "R6";
         end
         6'h23: begin
            ea = a + sx;
            if (ins[20:16] != 5'd0) rf[ins[20:16]] = rmem[ea[9:2]];
            ncyc = 5; is_lw = 1'b1; prev_tag = "R4";
         end
         6'h2B: begin
            ea = a + sx; sdata = b;
            rmem[ea[9:2]] = sdata;
            ncyc = 4; is_sw = 1'b1; prev_tag = "R5";
         end
         6'h04: begin
            if (a == b) mpc = mpc + (sx << 2);
            ncyc = 3; prev_tag = "R7";
         end
         6'h02: begin
            mpc = {mpc[31:28], ins[25:0], 2'b00};
            ncyc = 3; prev_tag = "R8";
         end
         default: begin
            ncyc = 2; prev_tag = "R3";
         end
      endcase
      if (cur_pc == 32'd112) halts++;
      phase = 0;
   endtask

   task automatic cycle_check();
      bit exp_rd, exp_wr;
      exp_rd = (phase == 0) || (is_lw && phase == 3);
      exp_wr = is_sw && phase == 3;
      chk(mem_rd == exp_rd && mem_wr == exp_wr,
          (phase == 0) ? {"R3 R10 ", ftag} : "R3 R10", "strobes",
          {30'd0, mem_rd, mem_wr}, {30'd0, exp_rd, exp_wr});
      if (phase == 0)
         chk(mem_addr == cur_pc, {"R2 ", ftag}, "fetch address", mem_addr, cur_pc);
      if (is_lw && phase == 3)
         chk(mem_addr == ea, "R4", "load address", mem_addr, ea);
      if (exp_wr) begin
         chk(mem_addr == ea, "R5", "store address", mem_addr, ea);
         chk(mem_wdata == sdata, "R5", "store data", mem_wdata, sdata);
      end
   endtask

   initial begin
      rst_n = 1'b0;
      for (int i = 0; i < 256; i++) rmem[i] = init_word(i);
      for (int i = 0; i < 32; i++) rf[i] = 32'h0;
      mpc = 32'h0; halts = 0; prev_tag = "R1";
      repeat (3) @(negedge clk);
      #1;
      chk(mem_rd && !mem_wr && mem_addr == 32'h0, "R1", "reset bus state",
          {mem_addr[29:0], mem_rd, mem_wr}, 32'h2);
      @(negedge clk);
      rst_n = 1'b1;
      decode_next();
      #1 cycle_check();
      while (halts < 3) begin
         @(negedge clk);
         phase++;
         if (phase == ncyc) decode_next();
         #1 cycle_check();
      end
      for (int w = 160; w <= 170; w++)
         chk(dmem[w] == rmem[w], "R6 R7 R8 R9", "data word", dmem[w], rmem[w]);
      chk(dmem[160] == 32'd4, "R6", "add result", dmem[160], 32'd4);
      chk(dmem[164] == 32'd1, "R6", "signed slt", dmem[164], 32'd1);
      chk(dmem[166] == 32'd0, "R9", "register 0 store", dmem[166], 32'd0);
      chk(dmem[167] == 32'hDEAD_BEEF, "R7", "skipped store", dmem[167], 32'hDEAD_BEEF);
      chk(dmem[168] == 32'd21, "R7", "loop sum", dmem[168], 32'd21);
      chk(dmem[169] == 32'hDEAD_BEEF, "R8", "jumped-over store", dmem[169], 32'hDEAD_BEEF);
      chk(dmem[170] == 32'hFFFF_FFFD, "R5", "based store", dmem[170], 32'hFFFF_FFFD);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R3 watchdog: actual=%0d expected=%0d", halts, 3);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule